// File: doc/BRIEF.md
# Sleep and Watchdog Timer Unit

This unit runs in the slow 32 kHz clock domain. A free-running count divides that clock into a periodic wake-up interval. The length of the interval comes from a two-bit selector. Each time the interval ends, the unit sends a one-cycle sleep interrupt pulse. The pulse is produced whether or not the processor is asleep.

A small watchdog counts these interval ends. If software has not serviced it by the third one, the watchdog issues a one-cycle reset pulse. The watchdog stays disabled until software clears the power-on status flag. From then on, only a power-on reset can turn it off again.

Software works the unit through two register writes that come from the fast domain, one for the watchdog-clear register and one for the status/control register. Each write is signalled by flipping a toggle line and holding the data steady. The toggle is synchronised into the slow domain before the write takes effect.

Top module: `sleep_wdt_timer`

## Requirements
- R1: While power-on reset is asserted, and right after it is released, the power-on flag reads 1, the watchdog-reset flag reads 0, and both the sleep interrupt and the watchdog reset are low.
- R2: The sleep interrupt is a one-cycle pulse repeating every P slow cycles, where P is 64, 512, 4096 or 32768 for a period select of 0, 1, 2 or 3.
- R3: Writing 0x38 to the watchdog-clear register restarts the periodic count, so the next sleep interrupt follows the write's acting edge by exactly P cycles.
- R4: While enabled, the watchdog counts sleep-interrupt events. On the third one it drives a one-cycle reset pulse in the same cycle as that interrupt, and then starts counting again from zero.
- R5: Any write to the watchdog-clear register zeroes the watchdog count. A value other than 0x38 leaves the periodic count undisturbed.
- R6: A status/control write with bit 4 at 0 clears the power-on flag. A write with bit 4 at 1 never sets it.
- R7: The watchdog is disabled while the power-on flag is 1. Once the flag is cleared, only power-on reset disables the watchdog again.
- R8: The watchdog-reset flag is set by each watchdog reset pulse and stays set. A status/control write with bit 5 at 0 clears it.
- R9: A write acts on the third rising slow-clock edge after its toggle line changes, which is the two-stage synchronizer plus the edge detect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow 32 kHz clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| clr_tgl | input | 1 | Toggles once per watchdog-clear register write |
| clr_data | input | 8 | Data of the watchdog-clear write, held stable |
| scr_tgl | input | 1 | Toggles once per status/control register write |
| scr_data | input | 8 | Data of the status/control write: bit 4 power-on flag, bit 5 watchdog flag |
| period_sel | input | 2 | Selects the sleep period |
| sleep_irq | output | 1 | One-cycle periodic sleep interrupt |
| wdt_reset | output | 1 | One-cycle watchdog reset |
| por_flag | output | 1 | Power-on status flag |
| wdt_flag | output | 1 | Sticky watchdog-reset flag |

## Verification
The hardest case is a clear with a value other than 0x38 that lands partway through a period. After such a write the watchdog count is zero, but the periodic count keeps its phase, so the next reset has to arrive on the third interrupt after the write and not at a fixed delay.

To reach this case, the stimulus waits for an interrupt and then waits a random number of cycles before issuing the write. It then checks two things: the following interrupt still falls P cycles after the previous one, and the reset coincides with the third interrupt.

Random sequences mix clears with 0x38 and other values under different period selects.

// File: rtl/sleep_wdt_timer.sv
module sleep_wdt_timer #(
  parameter int         BASE_LOG  = 6,
  parameter int         STEP_LOG  = 3,
  parameter int         SEL_W     = 2,
  parameter int         DATA_W    = 8,
  parameter int         WDT_W     = 2,
  parameter int         WDT_LIMIT = 3,
  parameter logic [7:0] MAGIC     = 8'h38,
  parameter int         POR_BIT   = 4,
  parameter int         WFLAG_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_tgl,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              scr_tgl,
  input  logic [DATA_W-1:0] scr_data,
  input  logic [SEL_W-1:0]  period_sel,
  output logic              sleep_irq,
  output logic              wdt_reset,
  output logic              por_flag,
  output logic              wdt_flag
);
  localparam int CNT_W = BASE_LOG + STEP_LOG * ((1 << SEL_W) - 1);

  logic [2:0]       clr_s, scr_s;
  logic [CNT_W-1:0] cnt, mask;
  logic [WDT_W-1:0] wcnt;
  logic             clr_pulse, scr_pulse, clr_magic, tc, wdt_en, fire;
  int               shamt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clr_s <= '0;
      scr_s <= '0;
    end else begin
      clr_s <= {clr_s[1:0], clr_tgl};
      scr_s <= {scr_s[1:0], scr_tgl};
    end

  assign clr_pulse = clr_s[2] ^ clr_s[1];
  assign scr_pulse = scr_s[2] ^ scr_s[1];
  assign clr_magic = clr_pulse && (clr_data[7:0] == MAGIC);

  assign shamt = BASE_LOG + STEP_LOG * int'(period_sel);
  assign mask  = (CNT_W'(1) << shamt) - CNT_W'(1);
  assign tc    = (cnt & mask) == mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt       <= '0;
      sleep_irq <= 1'b0;
    end else begin
      cnt       <= clr_magic ? '0 : cnt + CNT_W'(1);
      sleep_irq <= tc && !clr_magic;
    end

  assign wdt_en = !por_flag;
  assign fire   = wdt_en && !clr_pulse && tc && (wcnt == WDT_W'(WDT_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wcnt      <= '0;
      wdt_reset <= 1'b0;
    end else begin
      wdt_reset <= fire;
      if (clr_pulse || !wdt_en || fire) wcnt <= '0;
      else if (tc)                      wcnt <= wcnt + WDT_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      por_flag <= 1'b1;
      wdt_flag <= 1'b0;
    end else begin
      if (scr_pulse && !scr_data[POR_BIT]) por_flag <= 1'b0;
      if (fire)                            wdt_flag <= 1'b1;
      else if (scr_pulse && !scr_data[WFLAG_BIT]) wdt_flag <= 1'b0;
    end

  logic unused_scr_bits;
  assign unused_scr_bits = ^{scr_data, clr_data};

  p_irq_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_irq |=> !sleep_irq);
  p_wdt_with_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> sleep_irq);
  p_wdt_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);
  p_por_never_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !por_flag |=> !por_flag);
  p_wdt_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> !por_flag);
  p_flag_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> wdt_flag);
endmodule

// File: tb/sleep_wdt_timer_bench.sv
module sleep_wdt_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_tgl = 1'b0, scr_tgl = 1'b0;
  logic [7:0] clr_data = '0, scr_data = '0;
  logic [1:0] period_sel = '0;
  logic       sleep_irq, wdt_reset, por_flag, wdt_flag;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sleep_wdt_timer u_sleep_wdt_timer (
    .clk(clk), .rst_n(rst_n), .clr_tgl(clr_tgl), .clr_data(clr_data),
    .scr_tgl(scr_tgl), .scr_data(scr_data), .period_sel(period_sel),
    .sleep_irq(sleep_irq), .wdt_reset(wdt_reset), .por_flag(por_flag),
    .wdt_flag(wdt_flag));

  function automatic int period(input int sel);
    return 1 << (6 + 3 * sel);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clr_write(input logic [7:0] v);
    @(negedge clk); clr_data = v; clr_tgl = ~clr_tgl;
  endtask

  task automatic scr_write(input logic [7:0] v);
    @(negedge clk); scr_data = v; scr_tgl = ~scr_tgl;
    repeat (3) step();
  endtask

  task automatic wait_irq(output int n, output int w);
    n = 0;
    do begin step(); n++; end while (!sleep_irq && n < 40000);
    w = int'(wdt_reset);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, w, r;
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) step();
    chk("R1 por during reset", int'(por_flag), 1);
    rst_n = 1'b1;
    step();
    chk("R1 por", int'(por_flag), 1);
    chk("R1 wflag", int'(wdt_flag), 0);
    chk("R1 irq", int'(sleep_irq), 0);
    chk("R1 wdt", int'(wdt_reset), 0);

    for (int s = 0; s < 3; s++) begin
      wait_irq(n, w);
      period_sel = 2'(s);
      clr_write(8'h38);
      wait_irq(n, w);
      chk("R3/R9 magic clear to irq", n, 3 + period(s));
      wait_irq(n, w);
      chk("R2 period", n, period(s));
      step();
      chk("R2 irq one cycle", int'(sleep_irq), 0);
    end

    period_sel = 2'd3;
    clr_write(8'h38);
    wait_irq(n, w);
    chk("R2/R3 longest period", n, 3 + period(3));
    period_sel = 2'd0;
    clr_write(8'h38);
    wait_irq(n, w);
    chk("R3 back to short", n, 67);

    for (int k = 0; k < 4; k++) begin
      wait_irq(n, w);
      chk("R7 disabled no wdt", w, 0);
    end

    scr_write(8'h30);
    chk("R6 bit4 one keeps por", int'(por_flag), 1);
    scr_write(8'h20);
    chk("R6 bit4 zero clears por", int'(por_flag), 0);
    scr_write(8'h30);
    chk("R6 cannot set por", int'(por_flag), 0);

    wait_irq(n, w);
    clr_write(8'h38);
    wait_irq(n, w);
    chk("R4 first overflow", w, 0);
    wait_irq(n, w);
    chk("R4 second overflow", w, 0);
    wait_irq(n, w);
    chk("R4 third overflow fires", w, 1);
    chk("R8 flag set", int'(wdt_flag), 1);
    step();
    chk("R4 wdt one cycle", int'(wdt_reset), 0);
    chk("R8 flag sticky", int'(wdt_flag), 1);
    wait_irq(n, w); wait_irq(n, w);
    chk("R4 restart no early fire", w, 0);
    wait_irq(n, w);
    chk("R7 still enabled, R4 refire", w, 1);

    wait_irq(n, w); wait_irq(n, w);
    r = 5 + int'($urandom % 36);
    repeat (r) step();
    clr_write(8'h55);
    wait_irq(n, w);
    chk("R5 timer undisturbed", n, 64 - r);
    chk("R5 count cleared one", w, 0);
    wait_irq(n, w);
    chk("R5 count cleared two", w, 0);
    wait_irq(n, w);
    chk("R5 fires third after write", w, 1);

    scr_write(8'h10);
    chk("R8 flag cleared", int'(wdt_flag), 0);

    for (int it = 0; it < 10; it++) begin
      wait_irq(n, w);
      if ($urandom % 2 == 0) begin
        int s;
        s = int'($urandom % 2);
        period_sel = 2'(s);
        clr_write(8'h38);
        wait_irq(n, w);
        chk("R3 random magic", n, 3 + period(s));
      end else begin
        int p;
        p = period(int'(period_sel));
        r = int'($urandom % (p / 2));
        do v = 8'($urandom); while (v == 8'h38);
        repeat (r) step();
        clr_write(v);
        wait_irq(n, w);
        chk("R5 random plain clear", n, p - r);
      end
    end

    @(negedge clk); rst_n = 1'b0;
    step();
    chk("R1 por again", int'(por_flag), 1);
    chk("R1 wflag cleared", int'(wdt_flag), 0);
    @(negedge clk); rst_n = 1'b1;
    period_sel = 2'd0;
    for (int k = 0; k < 4; k++) begin
      wait_irq(n, w);
      chk("R7 reset disables wdt", w, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule